// File: doc/BRIEF.md
# Root-Port Interrupt Collector

This block gathers the interrupt sources of a PCIe root port and presents them to the processor as one interrupt line. Four legacy INTx level inputs are captured into sticky status bits. Inbound memory writes are also watched. A write whose address equals a software-programmed target is taken as a message-signalled interrupt, and its data word names one of up to 32 vectors. That vector is latched in a separate MSI status register. Any pending vector raises a summary bit in the main status word.

Software reaches the block through a small word-addressed register port. Word 0 is the main status. Word 1 is the mask. Word 2 is the MSI vector status. Word 3 is the MSI target address. Both status registers clear by writing 1 to a bit. The output `irq_out` is the OR of every status bit whose mask bit is 0.

Reads pass through a two-state machine. `RD_IDLE` waits for a read strobe. A strobe moves it to `RD_RESP`, in which the captured word is presented with `reg_rvalid` high for one cycle. From `RD_RESP` the machine goes back to `RD_IDLE`, unless a new strobe arrives, in which case it stays in `RD_RESP` for the next read.

Top module: `pcie_irq_aggregator`

## Requirements
- R1: After reset, main status, MSI status and target address read 0, the mask reads 0x008F0000 (everything masked), `irq_out` is low and `reg_rvalid` is low.
- R2: A high level on `intx_in[n]` at a clock edge sets main status bit 16+n (INTA at bit 16 through INTD at bit 19). The bit stays set after the input drops.
- R3: An inbound write is taken as an MSI only when `in_wr_addr` equals the target address and `in_wr_data` is below 32. It then sets MSI status bit `in_wr_data`. Writes to any other address, and data of 32 or more, leave the MSI status unchanged.
- R4: Main status bit 23 is set in the cycle after any MSI status bit is set. It stays set after the vectors are cleared, until a 1 is written to bit 23 while no vector is pending.
- R5: Writing a 1 to a bit of the main status (bits 23, 19:16) or of the MSI status clears it. Bits written with 0 keep their value.
- R6: When a bit is set and cleared in the same cycle, the set wins. This covers an MSI arriving while its vector is cleared, and an INTx input still high while its bit is cleared.
- R7: Mask bits 19:16 mask the INTx bits and mask bit 23 masks the summary, with 1 meaning masked. `irq_out` is high exactly when some unmasked status bit is set.
- R8: A read strobe at word address 0..3 (status, mask, MSI status, target) yields `reg_rvalid` high with that register's value on `reg_rdata` in the following cycle.
- R9: The target address register holds all 32 written bits and reads them back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intx_in | input | 4 | Legacy INTA..INTD levels, synchronous to clk |
| in_wr_valid | input | 1 | Inbound memory write present this cycle |
| in_wr_addr | input | 32 | Inbound write address |
| in_wr_data | input | 32 | Inbound write data word (vector number) |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the strobe |
| irq_out | output | 1 | Combined interrupt request |

## Verification
An inbound MSI or an INTx level becomes visible in its status bit at the edge that samples it. The summary bit follows one edge later. A register write changes state at its own edge, and `irq_out` follows combinationally. Read data appears one cycle after the strobe. The bench drives all inputs on the falling edge. It inserts an idle cycle before it reads the summary bit. A scoreboard queue holds the expected value of each read, and the monitor compares it on the falling edge where `reg_rvalid` is high.

// File: rtl/pia_pkg.sv
package pia_pkg;
    localparam int DATA_W      = 32;
    localparam int INTX_N      = 4;
    localparam int INTX_LSB    = 16;
    localparam int SUMMARY_BIT = 23;

    typedef enum logic [1:0] {
        WORD_STATUS = 2'd0,
        WORD_MASK   = 2'd1,
        WORD_MSI    = 2'd2,
        WORD_TARGET = 2'd3
    } reg_word_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/pia_intx_status.sv
module pia_intx_status #(
    parameter int NUM_SRC = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] level_in,
    input  logic [NUM_SRC-1:0] clr,
    output logic [NUM_SRC-1:0] status
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                status[g] <= 1'b0;
            else
                status[g] <= (status[g] & ~clr[g]) | level_in[g];
        end
    end

    AST_INTX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (|level_in) |=> ((status & $past(level_in)) == $past(level_in))); // R2

    AST_INTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr == '0) && (status != '0)) |=> ((status & $past(status)) == $past(status))); // R5
endmodule

// File: rtl/pia_msi_capture.sv
module pia_msi_capture #(
    parameter int NUM_VEC = 32,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_wr_valid,
    input  logic [DW-1:0]      in_wr_addr,
    input  logic [DW-1:0]      in_wr_data,
    input  logic [DW-1:0]      target_addr,
    input  logic [NUM_VEC-1:0] vec_clr,
    input  logic               summ_clr,
    output logic [NUM_VEC-1:0] vec_status,
    output logic               summary
);
    localparam int VEC_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

    logic             hit;
    logic [VEC_W-1:0] vec_idx;
    logic             any_pending;

    assign hit         = in_wr_valid && (in_wr_addr == target_addr)
                         && (in_wr_data < DW'(NUM_VEC));
    assign vec_idx     = in_wr_data[VEC_W-1:0];
    assign any_pending = |vec_status;

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
        logic set_here;
        assign set_here = hit && (vec_idx == VEC_W'(v));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                vec_status[v] <= 1'b0;
            else
                vec_status[v] <= (vec_status[v] & ~vec_clr[v]) | set_here;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            summary <= 1'b0;
        else
            summary <= any_pending | (summary & ~summ_clr);
    end

    AST_MSI_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> vec_status[$past(vec_idx)]); // R6

    AST_MSI_MISS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && (vec_clr == '0)) |=> (vec_status == $past(vec_status))); // R3

    AST_SUMMARY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (|vec_status) |=> summary); // R4
endmodule

// File: rtl/pia_regif.sv
module pia_regif
    import pia_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [1:0]         reg_addr,
    input  logic [DW-1:0]      reg_wdata,
    input  logic [DW-1:0]      status_word,
    input  logic [NUM_VEC-1:0] vec_status,
    output logic [INTX_N-1:0]  intx_clr,
    output logic               summ_clr,
    output logic [NUM_VEC-1:0] vec_clr,
    output logic [INTX_N-1:0]  mask_intx,
    output logic               mask_summ,
    output logic [DW-1:0]      target_addr,
    output logic [DW-1:0]      reg_rdata,
    output logic               reg_rvalid
);
    reg_word_e sel;
    rd_state_e rd_state, rd_next;
    logic      wr_status, wr_mask, wr_msi, wr_target;
    logic [DW-1:0] mask_word, msi_word, rd_mux;

    assign sel       = reg_word_e'(reg_addr);
    assign wr_status = reg_wr_en && (sel == WORD_STATUS);
    assign wr_mask   = reg_wr_en && (sel == WORD_MASK);
    assign wr_msi    = reg_wr_en && (sel == WORD_MSI);
    assign wr_target = reg_wr_en && (sel == WORD_TARGET);

    assign intx_clr = wr_status ? reg_wdata[INTX_LSB +: INTX_N] : '0;
    assign summ_clr = wr_status && reg_wdata[SUMMARY_BIT];
    assign vec_clr  = wr_msi ? reg_wdata[NUM_VEC-1:0] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_intx <= '1;
            mask_summ <= 1'b1;
        end else if (wr_mask) begin
            mask_intx <= reg_wdata[INTX_LSB +: INTX_N];
            mask_summ <= reg_wdata[SUMMARY_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            target_addr <= '0;
        else if (wr_target)
            target_addr <= reg_wdata;
    end

    always_comb begin
        mask_word = '0;
        mask_word[INTX_LSB +: INTX_N] = mask_intx;
        mask_word[SUMMARY_BIT]        = mask_summ;
        msi_word = '0;
        msi_word[NUM_VEC-1:0] = vec_status;
        unique case (sel)
            WORD_STATUS: rd_mux = status_word;
            WORD_MASK:   rd_mux = mask_word;
            WORD_MSI:    rd_mux = msi_word;
            WORD_TARGET: rd_mux = target_addr;
        endcase
    end

    // read state machine: next-state logic
    always_comb begin
        rd_next = rd_state;
        unique case (rd_state)
            RD_IDLE: rd_next = reg_rd_en ? RD_RESP : RD_IDLE;
            RD_RESP: rd_next = reg_rd_en ? RD_RESP : RD_IDLE;
        endcase
    end

    // read state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_state <= RD_IDLE;
        else
            rd_state <= rd_next;
    end

    // read state machine: data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd_en)
            reg_rdata <= rd_mux;
    end

    // read state machine: outputs
    always_comb begin
        unique case (rd_state)
            RD_IDLE: reg_rvalid = 1'b0;
            RD_RESP: reg_rvalid = 1'b1;
        endcase
    end

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> reg_rvalid); // R8

    AST_READ_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd_en |=> !reg_rvalid); // R8

    AST_TARGET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_target |=> $stable(target_addr)); // R9
endmodule

// File: rtl/pcie_irq_aggregator.sv
module pcie_irq_aggregator
    import pia_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        intx_in,
    input  logic              in_wr_valid,
    input  logic [31:0]       in_wr_addr,
    input  logic [31:0]       in_wr_data,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_rvalid,
    output logic              irq_out
);
    logic [INTX_N-1:0]  intx_status, intx_clr, mask_intx;
    logic [NUM_VEC-1:0] vec_status, vec_clr;
    logic               summary, summ_clr, mask_summ;
    logic [DATA_W-1:0]  target_addr, status_word;

    always_comb begin
        status_word = '0;
        status_word[INTX_LSB +: INTX_N] = intx_status;
        status_word[SUMMARY_BIT]        = summary;
    end

    pia_intx_status #(.NUM_SRC(INTX_N)) u_intx (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (intx_in),
        .clr      (intx_clr),
        .status   (intx_status)
    );

    pia_msi_capture #(.NUM_VEC(NUM_VEC), .DW(DATA_W)) u_msi (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_wr_valid (in_wr_valid),
        .in_wr_addr  (in_wr_addr),
        .in_wr_data  (in_wr_data),
        .target_addr (target_addr),
        .vec_clr     (vec_clr),
        .summ_clr    (summ_clr),
        .vec_status  (vec_status),
        .summary     (summary)
    );

    pia_regif #(.NUM_VEC(NUM_VEC), .DW(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_rd_en   (reg_rd_en),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .status_word (status_word),
        .vec_status  (vec_status),
        .intx_clr    (intx_clr),
        .summ_clr    (summ_clr),
        .vec_clr     (vec_clr),
        .mask_intx   (mask_intx),
        .mask_summ   (mask_summ),
        .target_addr (target_addr),
        .reg_rdata   (reg_rdata),
        .reg_rvalid  (reg_rvalid)
    );

    assign irq_out = (|(intx_status & ~mask_intx)) | (summary & ~mask_summ);

    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((&mask_intx) && mask_summ) |-> !irq_out); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((intx_status == '0) && !summary) |-> !irq_out); // R7
endmodule

// File: tb/pcie_irq_aggregator_tb.sv
module pcie_irq_aggregator_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] TGT = 32'h1000_0040;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  intx_in = '0;
    logic        in_wr_valid = 1'b0;
    logic [31:0] in_wr_addr = '0;
    logic [31:0] in_wr_data = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcie_irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .intx_in(intx_in),
        .in_wr_valid(in_wr_valid), .in_wr_addr(in_wr_addr), .in_wr_data(in_wr_data),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .irq_out(irq_out)
    );

    // monitor: compares read data against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && reg_rvalid) begin
            checks++;
            if (q_exp.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected read data actual=%h expected=none", reg_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                if (reg_rdata !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, reg_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a; reg_rd_en = 1'b1;
        q_exp.push_back(exp); q_tag.push_back(tag);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic inbound(input logic [31:0] a, input logic [31:0] d);
        in_wr_addr = a; in_wr_data = d; in_wr_valid = 1'b1;
        @(negedge clk);
        in_wr_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        checks++;
        if (irq_out !== exp) begin
            errors++;
            $display("FAIL %s irq_out actual=%b expected=%b", tag, irq_out, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk_irq(1'b0, "R1 reset");
        checks++;
        if (reg_rvalid !== 1'b0) begin
            errors++;
            $display("FAIL R1 rvalid actual=%b expected=0", reg_rvalid);
        end
        rd(2'd0, 32'h0000_0000, "R1 status reset");
        rd(2'd1, 32'h008F_0000, "R1 mask reset");
        rd(2'd2, 32'h0000_0000, "R1 msi reset");
        rd(2'd3, 32'h0000_0000, "R1 target reset");

        // R9 target programming
        wr(2'd3, TGT);
        rd(2'd3, TGT, "R9 target readback");

        // R3 capture of vector 5, R4 summary, R7 still masked
        inbound(TGT, 32'd5);
        rd(2'd2, 32'h0000_0020, "R3 vector 5");
        idle(1);
        rd(2'd0, 32'h0080_0000, "R4 summary set");
        chk_irq(1'b0, "R7 summary masked");
        wr(2'd1, 32'h000F_0000);
        chk_irq(1'b1, "R7 summary unmasked");

        // R3 ignored writes
        inbound(TGT ^ 32'h4, 32'd7);
        rd(2'd2, 32'h0000_0020, "R3 wrong address ignored");
        inbound(TGT, 32'd40);
        rd(2'd2, 32'h0000_0020, "R3 out of range data ignored");
        inbound(TGT, 32'd31);
        rd(2'd2, 32'h8000_0020, "R3 vector 31");

        // R5 write one to clear
        wr(2'd2, 32'h0000_0020);
        rd(2'd2, 32'h8000_0000, "R5 clear vector 5");
        wr(2'd2, 32'h0000_0000);
        rd(2'd2, 32'h8000_0000, "R5 zero write keeps");
        wr(2'd2, 32'h8000_0000);
        rd(2'd2, 32'h0000_0000, "R5 clear vector 31");
        idle(1);
        rd(2'd0, 32'h0080_0000, "R4 summary stays after vectors cleared");
        chk_irq(1'b1, "R4 summary still drives irq");
        wr(2'd0, 32'h0080_0000);
        rd(2'd0, 32'h0000_0000, "R4 summary cleared");
        chk_irq(1'b0, "R7 irq drops");

        // R6 set wins over clear
        inbound(TGT, 32'd3);
        in_wr_addr = TGT; in_wr_data = 32'd3; in_wr_valid = 1'b1;
        reg_addr = 2'd2; reg_wdata = 32'h0000_0008; reg_wr_en = 1'b1;
        @(negedge clk);
        in_wr_valid = 1'b0; reg_wr_en = 1'b0;
        rd(2'd2, 32'h0000_0008, "R6 msi set wins");
        wr(2'd2, 32'h0000_0008);
        idle(1);
        wr(2'd0, 32'h0080_0000);
        rd(2'd0, 32'h0000_0000, "R5 all msi state cleared");

        // R2 INTx capture, sticky
        intx_in = 4'b0010;
        @(negedge clk);
        intx_in = 4'b0000;
        rd(2'd0, 32'h0002_0000, "R2 INTB sticky");
        chk_irq(1'b0, "R7 intx masked");
        wr(2'd1, 32'h0000_0000);
        chk_irq(1'b1, "R7 intx unmasked");

        // R6 clear while level high, R5 independent clear
        intx_in = 4'b0001;
        @(negedge clk);
        wr(2'd0, 32'h0001_0000);
        rd(2'd0, 32'h0003_0000, "R6 INTA level re-sets");
        wr(2'd0, 32'h0002_0000);
        rd(2'd0, 32'h0001_0000, "R5 INTB cleared alone");
        intx_in = 4'b0000;
        @(negedge clk);
        wr(2'd0, 32'h0001_0000);
        rd(2'd0, 32'h0000_0000, "R5 INTA cleared");
        chk_irq(1'b0, "R7 nothing pending");

        // R2 INTD at bit 19, R7 per-bit mask
        wr(2'd1, 32'h0007_0000);
        intx_in = 4'b1000;
        @(negedge clk);
        intx_in = 4'b0000;
        rd(2'd0, 32'h0008_0000, "R2 INTD bit 19");
        chk_irq(1'b1, "R7 INTD unmasked");
        wr(2'd1, 32'h0008_0000);
        rd(2'd1, 32'h0008_0000, "R7 mask readback");
        chk_irq(1'b0, "R7 INTD masked");

        idle(3);
        checks++;
        if (q_exp.size() != 0) begin
            errors++;
            $display("FAIL R8 missing reads actual=%0d expected=0", q_exp.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule